// File: doc/BRIEF.md
# Multi-Device Tuning Bus Master

This block drives a three-wire serial bus (clock, enable, data) that is shared by several digitally tuned elements. Each element takes an 8-bit word. The word carries a 5-bit tuning code and a standby flag, and the element commits it on the falling edge of its enable line. The block takes a setting for each device and a start pulse. It takes a snapshot of the settings when it starts, then shifts the words out. It spaces every edge by a whole number of system-clock cycles. That number is worked out at elaboration from the system clock rate and the minimum bus times, always rounded up.

The `mode_i` input selects one of two wirings and is sampled at start. In dedicated-enable mode, every device has its own enable line and all devices share data line 0. Only devices flagged as changed are sent, one transaction each, in ascending index order. In shared-enable mode, enable line 0 serves every device and each device has its own data line. Every device is sent a word in one parallel transaction, and all of them commit on the same falling edge.

While the block is working, `busy_o` is high. When the final enable has fallen and its low gap has elapsed, `done_o` pulses for one cycle.

Top module: `dtune_bus_master`

## Requirements
- R1: Each word is 8 bits long and is sent MSB first as {2'b00, standby, code[4:0]}, so standby sits at bit 5. Each word gets exactly 8 rising clock edges while its enable is high.
- R2: With `mode_i`=0, device d is framed by `sen_o[d]` and its data goes on `sdat_o[0]`. Only devices whose `chg_i` bit is set are sent, in ascending index order, with each commit on its own enable fall. At most one enable is high at a time.
- R3: With `mode_i`=1, `sen_o[0]` frames all devices and device d's data goes on `sdat_o[d]`. Every device is sent whatever `chg_i` holds, and all devices commit on the same enable fall. `sen_o[d]` stays low for d>0.
- R4: The enable is high for at least 19.2 ns before the first rising clock edge of a word, and the clock only rises while an enable is high.
- R5: At least 19.2 ns pass between the last rising clock edge of a word and the fall of its enable.
- R6: After any enable falls, no enable rises again for at least 38.4 ns.
- R7: Each clock phase, high or low, lasts at least 19.23 ns, which keeps the bus clock at or below 26 MHz. Data changes only while the clock is low, never on a rising edge and never while the clock is high.
- R8: `busy_o` goes high in the cycle after a start is accepted. `done_o` is a single-cycle pulse that comes after the last enable falls. `busy_o` goes low in the next cycle.
- R9: While `busy_o` is low, `sclk_o`, `sen_o` and `sdat_o` are all low.
- R10: A start with `mode_i`=0 and no `chg_i` bit set produces no bus activity. `done_o` then pulses in the second cycle after start is sampled.
- R11: A start request while busy is ignored. Changes to the settings, the change flags or the start input during a run do not affect the words being sent.
- R12: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| mode_i | input | 1 | 0: dedicated enables, shared data; 1: shared enable, dedicated data |
| chg_i | input | N_DEV | Changed flag for each device (used in mode 0) |
| stby_i | input | N_DEV | Standby flag for each device |
| code_i | input | N_DEV*5 | 5-bit tuning code for each device, device d at [5d+4:5d] |
| busy_o | output | 1 | High while a sequence runs |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| sclk_o | output | 1 | Serial clock |
| sen_o | output | N_DEV | Enable lines |
| sdat_o | output | N_DEV | Data lines |

## Verification
Two functions can meet in one cycle: accepting a new start request, and shifting the word that is already in flight. To provoke this, the bench pulses start in the middle of a word, with new codes, new standby flags and every change flag set. It passes only if the decoded words still match the snapshot taken at the first start, the extra devices stay silent, and exactly one done pulse appears. A bus model at the pins decodes every word and times every edge against the nanosecond limits. In shared-enable mode it also confirms that every device commits on the same cycle.

// File: rtl/dtune_pkg.sv
`timescale 1ns/1ps
package dtune_pkg;
  localparam int unsigned WORD_W = 8;
  localparam int unsigned CODE_W = 5;

  // minimum bus times in ps
  localparam int unsigned PH_MIN_PS   = 19231;  // half period at 26 MHz, rounded up
  localparam int unsigned DSET_MIN_PS = 13200;
  localparam int unsigned ELEAD_MIN_PS = 19200;
  localparam int unsigned ETAIL_MIN_PS = 19200;
  localparam int unsigned EGAP_MIN_PS = 38400;

  typedef enum logic [2:0] {
    S_IDLE, S_PICK, S_LEAD, S_HIGH, S_LOW, S_TAIL, S_GAP, S_FIN
  } seq_state_e;

  function automatic int unsigned cyc_for(input int unsigned ps, input int unsigned per_ps);
    int unsigned c;
    c = (ps + per_ps - 1) / per_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dtune_pick.sv
`timescale 1ns/1ps
module dtune_pick #(
  parameter int unsigned N_DEV = 4,
  localparam int unsigned IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic [N_DEV-1:0] pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |pend_i;
    idx_o = '0;
    for (int i = N_DEV - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  always_comb begin
    if (any_o) begin
      AST_PICK_LOWEST: assert (pend_i[idx_o] &&
        ((pend_i & ((N_DEV'(1) << idx_o) - N_DEV'(1))) == '0)); // R2
    end
  end
endmodule

// File: rtl/dtune_lane.sv
`timescale 1ns/1ps
module dtune_lane
  import dtune_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              clr_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (clr_i)   sh_q <= '0;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
  end

  assign bit_o = sh_q[WORD_W-1];

  AST_LANE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && (shift_i || clr_i))); // R1
endmodule

// File: rtl/dtune_bus_master.sv
`timescale 1ns/1ps
module dtune_bus_master
  import dtune_pkg::*;
#(
  parameter int unsigned N_DEV       = 4,
  parameter int unsigned SYS_CLK_KHZ = 50000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    mode_i,
  input  logic [N_DEV-1:0]        chg_i,
  input  logic [N_DEV-1:0]        stby_i,
  input  logic [N_DEV*CODE_W-1:0] code_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    sclk_o,
  output logic [N_DEV-1:0]        sen_o,
  output logic [N_DEV-1:0]        sdat_o
);
  localparam int unsigned PER_PS   = 1000000000 / SYS_CLK_KHZ;
  localparam int unsigned HALF_CYC = max_u(cyc_for(PH_MIN_PS, PER_PS), cyc_for(DSET_MIN_PS, PER_PS));
  localparam int unsigned LEAD_CYC = max_u(cyc_for(ELEAD_MIN_PS, PER_PS), cyc_for(DSET_MIN_PS, PER_PS));
  localparam int unsigned TAIL_CYC = cyc_for(ETAIL_MIN_PS, PER_PS);
  localparam int unsigned GAP_CYC  = cyc_for(EGAP_MIN_PS, PER_PS);
  localparam int unsigned MAX_CYC  = max_u(max_u(HALF_CYC, LEAD_CYC), max_u(TAIL_CYC, GAP_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
  localparam int unsigned IDX_W    = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam int unsigned BIT_W    = $clog2(WORD_W);

  seq_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [IDX_W-1:0] idx_q, idx_d, pick_idx;
  logic [N_DEV-1:0] pend_q, pend_d;
  logic             pick_any;
  logic             mode_q;
  logic [N_DEV-1:0][WORD_W-1:0] word_q;
  logic             cap, ld, sh, clr;
  logic             sclk_q;
  logic [N_DEV-1:0] sen_q, sen_d;
  logic             en_act;

  dtune_pick #(.N_DEV(N_DEV)) u_pick (
    .pend_i (pend_q),
    .any_o  (pick_any),
    .idx_o  (pick_idx)
  );

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    idx_d  = idx_q;
    pend_d = pend_q;
    cap    = 1'b0;
    ld     = 1'b0;
    sh     = 1'b0;
    clr    = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        cap    = 1'b1;
        pend_d = mode_i ? '1 : chg_i;
        st_d   = S_PICK;
      end
      S_PICK: if (!pick_any) begin
        st_d = S_FIN;
      end else begin
        ld    = 1'b1;
        cnt_d = CNT_W'(LEAD_CYC - 1);
        st_d  = S_LEAD;
        if (mode_q) pend_d = '0;
        else begin
          pend_d[pick_idx] = 1'b0;
          idx_d = pick_idx;
        end
      end
      S_LEAD: if (cnt_q == '0) begin
        st_d  = S_HIGH;
        cnt_d = CNT_W'(HALF_CYC - 1);
        bit_d = BIT_W'(WORD_W - 1);
      end else cnt_d = cnt_q - 1'b1;
      S_HIGH: if (cnt_q == '0) begin
        if (bit_q == '0) begin
          st_d  = S_TAIL;
          cnt_d = CNT_W'(TAIL_CYC - 1);
        end else begin
          st_d  = S_LOW;
          cnt_d = CNT_W'(HALF_CYC - 1);
          sh    = 1'b1;  // data moves with the falling clock
          bit_d = bit_q - 1'b1;
        end
      end else cnt_d = cnt_q - 1'b1;
      S_LOW: if (cnt_q == '0) begin
        st_d  = S_HIGH;
        cnt_d = CNT_W'(HALF_CYC - 1);
      end else cnt_d = cnt_q - 1'b1;
      S_TAIL: if (cnt_q == '0) begin
        st_d  = S_GAP;
        cnt_d = CNT_W'(GAP_CYC - 1);
        clr   = 1'b1;
      end else cnt_d = cnt_q - 1'b1;
      S_GAP: if (cnt_q == '0) st_d = S_PICK;
             else cnt_d = cnt_q - 1'b1;
      S_FIN: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  assign en_act = (st_d == S_LEAD) || (st_d == S_HIGH) || (st_d == S_LOW) || (st_d == S_TAIL);

  always_comb begin
    for (int d = 0; d < N_DEV; d++) begin
      sen_d[d] = en_act && (mode_q ? (d == 0) : (idx_d == IDX_W'(d)));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      idx_q  <= '0;
      pend_q <= '0;
      mode_q <= 1'b0;
      word_q <= '0;
      sclk_q <= 1'b0;
      sen_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      idx_q  <= idx_d;
      pend_q <= pend_d;
      sclk_q <= (st_d == S_HIGH);
      sen_q  <= sen_d;
      if (cap) begin
        mode_q <= mode_i;
        for (int d = 0; d < N_DEV; d++) begin
          word_q[d] <= {2'b00, stby_i[d], code_i[d*CODE_W +: CODE_W]};
        end
      end
    end
  end

  for (genvar g = 0; g < N_DEV; g++) begin : g_lane
    logic [WORD_W-1:0] w;
    if (g == 0) begin : g_shared
      assign w = mode_q ? word_q[0] : word_q[pick_idx];
    end else begin : g_own
      assign w = mode_q ? word_q[g] : '0;
    end
    dtune_lane u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (ld && (mode_q || (g == 0))),
      .shift_i (sh),
      .clr_i   (clr),
      .word_i  (w),
      .bit_o   (sdat_o[g])
    );
  end

  assign busy_o = (st_q != S_IDLE);
  assign done_o = (st_q == S_FIN);
  assign sclk_o = sclk_q;
  assign sen_o  = sen_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && sen_o == '0 && sdat_o == '0)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R8
  AST_ONE_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sen_o)); // R2
  AST_CLK_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> (sen_o != '0)); // R4
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdat_o)); // R7
  AST_SHARED_EN_ONLY0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_q) |-> ((sen_o >> 1) == '0)); // R3
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sen_o == '0 && !sclk_o)); // R8
endmodule

// File: tb/sim_dtune_bus_master.sv
`timescale 1ns/1ps
module sim_dtune_bus_master;
  localparam int N = 4;
  localparam int CW = 5;
  localparam int PER_PS = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [N-1:0] chg = '0;
  logic [N-1:0] stby = '0;
  logic [N*CW-1:0] code = '0;
  logic busy, done, sclk;
  logic [N-1:0] sen, sdat;

  always #10 clk = ~clk;

  dtune_bus_master #(.N_DEV(N), .SYS_CLK_KHZ(50000)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .chg_i(chg), .stby_i(stby), .code_i(code),
    .busy_o(busy), .done_o(done), .sclk_o(sclk), .sen_o(sen), .sdat_o(sdat)
  );

  // {mode, chg[3:0], stby[3:0], code3, code2, code1, code0}
  localparam logic [28:0] VEC [6] = '{
    {1'b0, 4'b1111, 4'b0000, 5'h0A, 5'h15, 5'h00, 5'h1F},
    {1'b0, 4'b0101, 4'b0001, 5'h11, 5'h07, 5'h1C, 5'h03},
    {1'b0, 4'b1000, 4'b1000, 5'h1F, 5'h1F, 5'h1F, 5'h1F},
    {1'b1, 4'b0000, 4'b1010, 5'h1E, 5'h01, 5'h0D, 5'h12},
    {1'b1, 4'b0110, 4'b1111, 5'h1F, 5'h00, 5'h1F, 5'h00},
    {1'b0, 4'b0000, 4'b0110, 5'h04, 5'h08, 5'h10, 5'h02}
  };

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pin-level bus model
  int cyc = 0;
  logic sclk_p = 1'b0;
  logic [N-1:0] en_p = '0;
  logic [N-1:0] dat_p = '0;
  logic [7:0] shr [N] = '{default: 8'h00};
  int nbits [N] = '{default: 0};
  logic [7:0] got [N] = '{default: 8'h00};
  int got_bits [N] = '{default: 0};
  int got_t [N] = '{default: -1};
  int en_rise_t [N] = '{default: -1000};
  int last_rise_t [N] = '{default: -1000};
  int last_fall_any = -1000;
  int last_sclk_edge = -1000;
  int v_setup = 0, v_hold = 0, v_gap = 0, v_clk = 0, v_data = 0, v_stray = 0;
  int sclk_rises = 0;
  int done_cnt = 0;

  always @(negedge clk) begin
    logic en, dat, fell;
    cyc++;
    fell = 1'b0;
    if (done) done_cnt++;
    if (sclk && !sclk_p) sclk_rises++;
    if (sclk != sclk_p) begin
      if ((cyc - last_sclk_edge) * PER_PS < 19231) v_clk++;
      last_sclk_edge = cyc;
    end
    if (mode && ((sen >> 1) != '0)) v_stray++;
    for (int d = 0; d < N; d++) begin
      en  = mode ? sen[0] : sen[d];
      dat = mode ? sdat[d] : sdat[0];
      if (en && !en_p[d]) begin
        en_rise_t[d] = cyc;
        nbits[d] = 0;
        shr[d] = '0;
        if ((cyc - last_fall_any) * PER_PS < 38400) v_gap++;
      end
      if (sclk && !sclk_p && en) begin
        if ((cyc - en_rise_t[d]) * PER_PS < 19200) v_setup++;
        if (dat != dat_p[d]) v_data++;
        shr[d] = {shr[d][6:0], dat};
        nbits[d]++;
        last_rise_t[d] = cyc;
      end
      if (sclk && sclk_p && en && (dat != dat_p[d])) v_data++;
      if (!en && en_p[d]) begin
        if ((cyc - last_rise_t[d]) * PER_PS < 19200) v_hold++;
        got[d] = shr[d];
        got_bits[d] = nbits[d];
        got_t[d] = cyc;
        fell = 1'b1;
      end
      en_p[d] = en;
      dat_p[d] = dat;
    end
    if (fell) last_fall_any = cyc;
    sclk_p = sclk;
  end

  function automatic logic [7:0] exp_word(input int d);
    return {2'b00, stby[d], code[d*CW +: CW]};
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done && k < 3000) begin
      @(negedge clk);
      k++;
    end
    check(k < 3000, "R8 done arrives", k, 0);
  endtask

  task automatic run_vec(input logic [28:0] v);
    int t0, dc0, r0, s0, h0, g0, c0, x0, y0, k, prev;
    @(negedge clk);
    mode = v[28]; chg = v[27:24]; stby = v[23:20]; code = v[19:0];
    t0 = cyc; dc0 = done_cnt; r0 = sclk_rises;
    s0 = v_setup; h0 = v_hold; g0 = v_gap; c0 = v_clk + v_data; x0 = v_stray;
    pulse_start();
    check(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    wait_done(k);
    if (!mode && chg == '0) begin
      check(k == 1, "R10 done latency", k, 1);
      check(sclk_rises == r0, "R10 no clock edges", sclk_rises - r0, 0);
    end
    repeat (3) @(negedge clk);
    check(!busy, "R8 busy drops", int'(busy), 0);
    check(done_cnt - dc0 == 1, "R8 single done pulse", done_cnt - dc0, 1);
    for (int d = 0; d < N; d++) begin
      if (mode || chg[d]) begin
        check(got_t[d] > t0 && got_bits[d] == 8, mode ? "R3 device sent" : "R2 device sent",
              got_bits[d], 8);
        check(got[d] == exp_word(d), "R1 word value", int'(got[d]), int'(exp_word(d)));
      end else begin
        check(got_t[d] <= t0, "R2 unchanged device skipped", got_t[d], t0);
      end
    end
    if (!mode) begin
      prev = -1;
      for (int d = 0; d < N; d++) begin
        if (chg[d]) begin
          check(got_t[d] > prev, "R2 ascending order", got_t[d], prev + 1);
          prev = got_t[d];
        end
      end
    end else begin
      for (int d = 1; d < N; d++)
        check(got_t[d] == got_t[0], "R3 common commit", got_t[d], got_t[0]);
      check(v_stray == x0, "R3 other enables low", v_stray - x0, 0);
    end
    check(v_setup == s0, "R4 enable lead", v_setup - s0, 0);
    check(v_hold == h0, "R5 enable tail", v_hold - h0, 0);
    check(v_gap == g0, "R6 enable gap", v_gap - g0, 0);
    check(v_clk + v_data == c0, "R7 clock phase and data", v_clk + v_data - c0, 0);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int k, t0, dc0, bad;
    logic [7:0] w0, w1;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!sclk && sen == '0 && sdat == '0, "R12 bus low in reset", int'({sclk, sen, sdat}), 0);
    check(!busy && !done, "R12 status low in reset", int'({busy, done}), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 6; i++) run_vec(VEC[i]);

    // R11 start and input changes while busy
    @(negedge clk);
    mode = 1'b0; chg = 4'b0011; stby = 4'b0010;
    code = {5'h00, 5'h00, 5'h1A, 5'h05};
    w0 = exp_word(0); w1 = exp_word(1);
    t0 = cyc; dc0 = done_cnt;
    pulse_start();
    repeat (6) @(negedge clk);
    check(busy == 1'b1, "R11 still busy mid word", int'(busy), 1);
    code = '1; stby = '1; chg = '1;
    pulse_start();
    wait_done(k);
    repeat (4) @(negedge clk);
    check(done_cnt - dc0 == 1, "R11 one done only", done_cnt - dc0, 1);
    check(got[0] == w0 && got_t[0] > t0, "R11 device 0 keeps snapshot", int'(got[0]), int'(w0));
    check(got[1] == w1 && got_t[1] > t0, "R11 device 1 keeps snapshot", int'(got[1]), int'(w1));
    check(got_t[2] <= t0 && got_t[3] <= t0, "R11 late flags ignored", got_t[3], t0);

    // R9 idle rest with inputs moving but no start
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chg = chg ^ 4'b0101; code = code ^ 20'h5A5A5; mode = ~mode;
      if (sclk || sen != '0 || sdat != '0 || busy) bad++;
    end
    check(bad == 0, "R9 idle bus low", bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule